// File: doc/BRIEF.md
# In-Order Speculative Commit Controller

This block sits between the thread scheduler and the memory-side engines of a multithreaded core that runs threads speculatively. Each thread descriptor carries a frame pointer, a code pointer, a register-set number and a synchronisation count. A speculative thread adds three fields: an epoch that fixes its place in program order, a restart pointer, and the number of the address-tracking buffer that records its speculative reads. A descriptor whose epoch is zero is an ordinary, non-speculative thread, and its three added fields are zero.

A spawn port hands out a new epoch and a free tracking-buffer number for each new speculative thread. Threads that finish and want to retire are pushed into a dedicated in-order queue. The controller keeps the epoch that may retire next and compares it with the descriptor at the head of the queue. If they match and the tracking buffer of that thread reports no conflict, the descriptor goes to the post-store path. If there is a conflict, the descriptor is rewritten to restart at its restart pointer as a plain thread and goes to the preload path. In that case the program-order slot is held until the re-executed thread signals completion. Either way, the tracking buffer is returned to the pool.

The sequencer has four states:
- `ST_SCAN` waits for a head whose epoch matches.
- `ST_COMMIT` offers the head to post-store.
- `ST_RETRY` offers the rewritten head to preload.
- `ST_HOLD` waits for the retried thread to finish.

Its transitions are:
- `SCAN→COMMIT` on a match with a clear conflict flag.
- `SCAN→RETRY` on a match with the flag set.
- `COMMIT→SCAN` on the post-store handshake.
- `RETRY→HOLD` on the preload handshake.
- `HOLD→SCAN` on the completion pulse.
- Every state remains where it is when its condition is false.

Top module: `spec_commit_ctrl`

## Requirements
- R1: After reset, no output is valid, the queue accepts input, a spawn would return epoch 1 with buffer 0, and every buffer is free.
- R2: Spawned epochs count up from 1 by one per spawn handshake; after the all-ones value the next epoch is 1, so zero is never issued.
- R3: A spawn returns the lowest-numbered free buffer. Spawn ready is low when no buffer is free.
- R4: A head descriptor retires only when its epoch equals the next-epoch register, which starts at 1. A non-matching head stalls the queue, and entries behind it are never taken out of order.
- R5: A matching head with a clear conflict flag appears on the post-store port with every field unchanged. The next-epoch register advances (skipping zero) on the post-store handshake.
- R6: A matching head whose conflict flag (bit `abi` of `viol_flags`) is set appears on the preload port with the code pointer replaced by the restart pointer. Its epoch, restart pointer and buffer fields are zero, and its frame pointer, register set and sync count are unchanged.
- R7: After a retry handshake, no further descriptor retires until `retry_done` pulses; the next epoch then advances by one.
- R8: The buffer of a committed or retried descriptor is freed on its output handshake and becomes available to the next spawn.
- R9: The queue holds at most `Q_DEPTH` descriptors; `in_ready` is low while it is full.
- R10: While `ps_valid` or `pl_valid` is high without its ready, the offered descriptor stays unchanged and valid.
- R11: `ps_valid` and `pl_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_valid | input | 1 | Request for a new epoch and buffer |
| spawn_ready | output | 1 | A buffer is free |
| spawn_epoch | output | EPOCH_W | Epoch given on spawn handshake |
| spawn_abi | output | BUF_W | Buffer given on spawn handshake |
| in_valid | input | 1 | Descriptor ready to retire |
| in_ready | output | 1 | Queue has room |
| in_fp | input | ADDR_W | Frame pointer |
| in_ip | input | ADDR_W | Code pointer |
| in_rs | input | RS_W | Register set |
| in_sc | input | SC_W | Sync count |
| in_epoch | input | EPOCH_W | Epoch |
| in_rip | input | ADDR_W | Restart pointer |
| in_abi | input | BUF_W | Tracking buffer |
| viol_flags | input | NUM_BUF | Conflict flag per tracking buffer |
| ps_valid | output | 1 | Descriptor offered to post-store |
| ps_ready | input | 1 | Post-store accepts |
| ps_fp | output | ADDR_W | Frame pointer |
| ps_ip | output | ADDR_W | Code pointer |
| ps_rs | output | RS_W | Register set |
| ps_sc | output | SC_W | Sync count |
| ps_epoch | output | EPOCH_W | Epoch |
| ps_rip | output | ADDR_W | Restart pointer |
| ps_abi | output | BUF_W | Tracking buffer |
| pl_valid | output | 1 | Rewritten descriptor offered to preload |
| pl_ready | input | 1 | Preload accepts |
| pl_fp | output | ADDR_W | Frame pointer |
| pl_ip | output | ADDR_W | Restart pointer as code pointer |
| pl_rs | output | RS_W | Register set |
| pl_sc | output | SC_W | Sync count |
| pl_epoch | output | EPOCH_W | Zero |
| pl_rip | output | ADDR_W | Zero |
| pl_abi | output | BUF_W | Zero |
| retry_done | input | 1 | Retried thread has finished |

## Verification
The bench builds the block with a 3-bit epoch, four tracking buffers, a four-entry queue and 16-bit pointers. The narrow epoch makes the allocator and the next-epoch register wrap past the all-ones value many times during the random rounds. Because the pool size equals the queue depth, one directed case fills the queue and exhausts the pool at the same moment. A separate directed case pushes a later epoch ahead of an earlier one to show that the queue stalls and is not reordered.

// File: rtl/cc_pkg.sv
package cc_pkg;

    // Retirement sequencer states
    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_RETRY  = 2'd2,
        ST_HOLD   = 2'd3
    } cc_state_e;

endpackage

// File: rtl/cc_fifo.sv
module cc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push;

    assign push_ready = (cnt_q != CW'(DEPTH));
    assign do_push    = push_valid && push_ready;
    assign head_valid = (cnt_q != '0);
    assign head_data  = mem_q[rd_q];

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= ptr_inc(wr_q);
            if (pop)     rd_q <= ptr_inc(rd_q);
            case ({do_push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    // R9
    fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0);

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/cc_alloc.sv
module cc_alloc #(
    parameter int EPOCH_W = 8,
    parameter int NUM_BUF = 8,
    localparam int BUF_W  = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spawn_valid,
    output logic               spawn_ready,
    output logic [EPOCH_W-1:0] spawn_epoch,
    output logic [BUF_W-1:0]   spawn_abi,
    input  logic               rel_valid,
    input  logic [BUF_W-1:0]   rel_abi
);
    logic [NUM_BUF-1:0] used_q, used_d;
    logic [EPOCH_W-1:0] ep_q;
    logic [BUF_W-1:0]   pick;
    logic               found;
    logic               grant;

    function automatic logic [EPOCH_W-1:0] ep_inc(input logic [EPOCH_W-1:0] e);
        return (e == '1) ? EPOCH_W'(1) : e + 1'b1;
    endfunction

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                found = 1'b1;
                pick  = BUF_W'(i);
            end
        end
    end

    assign spawn_ready = found;
    assign spawn_epoch = ep_q;
    assign spawn_abi   = pick;
    assign grant       = spawn_valid && found;

    always_comb begin
        used_d = used_q;
        if (rel_valid) used_d[rel_abi] = 1'b0;
        if (grant)     used_d[pick]    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            ep_q   <= EPOCH_W'(1);
        end else begin
            used_q <= used_d;
            if (grant) ep_q <= ep_inc(ep_q);
        end
    end

    // R3
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !used_q[spawn_abi]);

    // R8
    rel_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> used_q[rel_abi]);

    // R2
    epoch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_epoch != '0);
endmodule

// File: rtl/spec_commit_ctrl.sv
module spec_commit_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RS_W    = 5,
    parameter int SC_W    = 8,
    parameter int EPOCH_W = 8,
    parameter int NUM_BUF = 8,
    parameter int Q_DEPTH = 8,
    localparam int BUF_W  = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spawn_valid,
    output logic               spawn_ready,
    output logic [EPOCH_W-1:0] spawn_epoch,
    output logic [BUF_W-1:0]   spawn_abi,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_fp,
    input  logic [ADDR_W-1:0]  in_ip,
    input  logic [RS_W-1:0]    in_rs,
    input  logic [SC_W-1:0]    in_sc,
    input  logic [EPOCH_W-1:0] in_epoch,
    input  logic [ADDR_W-1:0]  in_rip,
    input  logic [BUF_W-1:0]   in_abi,
    input  logic [NUM_BUF-1:0] viol_flags,
    output logic               ps_valid,
    input  logic               ps_ready,
    output logic [ADDR_W-1:0]  ps_fp,
    output logic [ADDR_W-1:0]  ps_ip,
    output logic [RS_W-1:0]    ps_rs,
    output logic [SC_W-1:0]    ps_sc,
    output logic [EPOCH_W-1:0] ps_epoch,
    output logic [ADDR_W-1:0]  ps_rip,
    output logic [BUF_W-1:0]   ps_abi,
    output logic               pl_valid,
    input  logic               pl_ready,
    output logic [ADDR_W-1:0]  pl_fp,
    output logic [ADDR_W-1:0]  pl_ip,
    output logic [RS_W-1:0]    pl_rs,
    output logic [SC_W-1:0]    pl_sc,
    output logic [EPOCH_W-1:0] pl_epoch,
    output logic [ADDR_W-1:0]  pl_rip,
    output logic [BUF_W-1:0]   pl_abi,
    input  logic               retry_done
);
    // Packed descriptor layout inside the queue
    localparam int OFF_ABI = 0;
    localparam int OFF_RIP = OFF_ABI + BUF_W;
    localparam int OFF_EPN = OFF_RIP + ADDR_W;
    localparam int OFF_SC  = OFF_EPN + EPOCH_W;
    localparam int OFF_RS  = OFF_SC + SC_W;
    localparam int OFF_IP  = OFF_RS + RS_W;
    localparam int OFF_FP  = OFF_IP + ADDR_W;
    localparam int DW      = OFF_FP + ADDR_W;

    cc_state_e          state_q, state_d;
    logic [EPOCH_W-1:0] next_ep_q;
    logic               ep_adv;
    logic               pop;
    logic               rel_valid;
    logic               head_valid;
    logic [DW-1:0]      head_data;
    logic [ADDR_W-1:0]  h_fp, h_ip, h_rip;
    logic [RS_W-1:0]    h_rs;
    logic [SC_W-1:0]    h_sc;
    logic [EPOCH_W-1:0] h_ep;
    logic [BUF_W-1:0]   h_abi;

    function automatic logic [EPOCH_W-1:0] ep_inc(input logic [EPOCH_W-1:0] e);
        return (e == '1) ? EPOCH_W'(1) : e + 1'b1;
    endfunction

    cc_fifo #(.W(DW), .DEPTH(Q_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .push_data  ({in_fp, in_ip, in_rs, in_sc, in_epoch, in_rip, in_abi}),
        .pop        (pop),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    cc_alloc #(.EPOCH_W(EPOCH_W), .NUM_BUF(NUM_BUF)) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .spawn_valid (spawn_valid),
        .spawn_ready (spawn_ready),
        .spawn_epoch (spawn_epoch),
        .spawn_abi   (spawn_abi),
        .rel_valid   (rel_valid),
        .rel_abi     (h_abi)
    );

    assign h_abi = head_data[OFF_ABI +: BUF_W];
    assign h_rip = head_data[OFF_RIP +: ADDR_W];
    assign h_ep  = head_data[OFF_EPN +: EPOCH_W];
    assign h_sc  = head_data[OFF_SC  +: SC_W];
    assign h_rs  = head_data[OFF_RS  +: RS_W];
    assign h_ip  = head_data[OFF_IP  +: ADDR_W];
    assign h_fp  = head_data[OFF_FP  +: ADDR_W];

    // Commit path carries the head as is
    assign ps_fp    = h_fp;
    assign ps_ip    = h_ip;
    assign ps_rs    = h_rs;
    assign ps_sc    = h_sc;
    assign ps_epoch = h_ep;
    assign ps_rip   = h_rip;
    assign ps_abi   = h_abi;

    // Retry path restarts at the restart pointer as a plain thread
    assign pl_fp    = h_fp;
    assign pl_ip    = h_rip;
    assign pl_rs    = h_rs;
    assign pl_sc    = h_sc;
    assign pl_epoch = '0;
    assign pl_rip   = '0;
    assign pl_abi   = '0;

    // State register and program-order register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SCAN;
            next_ep_q <= EPOCH_W'(1);
        end else begin
            state_q <= state_d;
            if (ep_adv) next_ep_q <= ep_inc(next_ep_q);
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        ps_valid  = 1'b0;
        pl_valid  = 1'b0;
        pop       = 1'b0;
        rel_valid = 1'b0;
        ep_adv    = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                if (head_valid && (h_ep == next_ep_q))
                    state_d = viol_flags[h_abi] ? ST_RETRY : ST_COMMIT;
            end
            ST_COMMIT: begin
                ps_valid = 1'b1;
                if (ps_ready) begin
                    pop       = 1'b1;
                    rel_valid = 1'b1;
                    ep_adv    = 1'b1;
                    state_d   = ST_SCAN;
                end
            end
            ST_RETRY: begin
                pl_valid = 1'b1;
                if (pl_ready) begin
                    pop       = 1'b1;
                    rel_valid = 1'b1;
                    state_d   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (retry_done) begin
                    ep_adv  = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // R11
    single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ps_valid && pl_valid));

    // R4
    commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid |-> ps_epoch == next_ep_q);

    // R10
    ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid && !ps_ready |=> ps_valid && $stable(ps_ip) && $stable(ps_epoch) && $stable(ps_fp));

    // R10
    pl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid && !pl_ready |=> pl_valid && $stable(pl_ip) && $stable(pl_fp));

    // R7
    hold_epoch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) && !retry_done |=> $stable(next_ep_q) && !ps_valid);

    // R5
    epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid && ps_ready |=> next_ep_q != $past(next_ep_q));
endmodule

// File: tb/spec_commit_ctrl_tb.sv
module spec_commit_ctrl_tb;
    localparam int AW = 16, RSW = 4, SCW = 6, EW = 3, NB = 4, QD = 4, BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          spawn_valid = 1'b0, spawn_ready;
    logic [EW-1:0] spawn_epoch;
    logic [BW-1:0] spawn_abi;
    logic          in_valid = 1'b0, in_ready;
    logic [AW-1:0] in_fp = '0, in_ip = '0, in_rip = '0;
    logic [RSW-1:0] in_rs = '0;
    logic [SCW-1:0] in_sc = '0;
    logic [EW-1:0] in_epoch = '0;
    logic [BW-1:0] in_abi = '0;
    logic [NB-1:0] viol_flags = '0;
    logic          ps_valid, ps_ready = 1'b0;
    logic [AW-1:0] ps_fp, ps_ip, ps_rip;
    logic [RSW-1:0] ps_rs;
    logic [SCW-1:0] ps_sc;
    logic [EW-1:0] ps_epoch;
    logic [BW-1:0] ps_abi;
    logic          pl_valid, pl_ready = 1'b0;
    logic [AW-1:0] pl_fp, pl_ip, pl_rip;
    logic [RSW-1:0] pl_rs;
    logic [SCW-1:0] pl_sc;
    logic [EW-1:0] pl_epoch;
    logic [BW-1:0] pl_abi;
    logic          retry_done = 1'b0;

    spec_commit_ctrl #(.ADDR_W(AW), .RS_W(RSW), .SC_W(SCW), .EPOCH_W(EW),
                       .NUM_BUF(NB), .Q_DEPTH(QD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .spawn_valid(spawn_valid), .spawn_ready(spawn_ready),
        .spawn_epoch(spawn_epoch), .spawn_abi(spawn_abi),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_fp(in_fp), .in_ip(in_ip), .in_rs(in_rs), .in_sc(in_sc),
        .in_epoch(in_epoch), .in_rip(in_rip), .in_abi(in_abi),
        .viol_flags(viol_flags),
        .ps_valid(ps_valid), .ps_ready(ps_ready),
        .ps_fp(ps_fp), .ps_ip(ps_ip), .ps_rs(ps_rs), .ps_sc(ps_sc),
        .ps_epoch(ps_epoch), .ps_rip(ps_rip), .ps_abi(ps_abi),
        .pl_valid(pl_valid), .pl_ready(pl_ready),
        .pl_fp(pl_fp), .pl_ip(pl_ip), .pl_rs(pl_rs), .pl_sc(pl_sc),
        .pl_epoch(pl_epoch), .pl_rip(pl_rip), .pl_abi(pl_abi),
        .retry_done(retry_done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    // Bench model
    logic [NB-1:0] m_free;
    logic [EW-1:0] m_ep;
    logic [AW-1:0] q_fp[4], q_ip[4], q_rip[4];
    logic [RSW-1:0] q_rs[4];
    logic [SCW-1:0] q_sc[4];
    logic [EW-1:0] q_ep[4];
    logic [BW-1:0] q_abi[4];
    bit            q_viol[4];

    function automatic logic [EW-1:0] ep_next(input logic [EW-1:0] e);
        return (e == '1) ? EW'(1) : e + 1'b1;
    endfunction

    function automatic logic [BW-1:0] lowest_free(input logic [NB-1:0] f);
        for (int i = 0; i < NB; i++) if (f[i]) return BW'(i);
        return '0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        spawn_valid = 1'b0; in_valid = 1'b0; ps_ready = 1'b0; pl_ready = 1'b0;
        retry_done = 1'b0; viol_flags = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_free = '1;
        m_ep = EW'(1);
    endtask

    task automatic spawn(input int k);
        @(negedge clk);
        spawn_valid = 1'b1;
        #0;
        chk(spawn_ready == 1'b1, "R3 spawn_ready", 64'(spawn_ready), 64'd1);
        chk(spawn_epoch == m_ep, "R2 epoch", 64'(spawn_epoch), 64'(m_ep));
        chk(spawn_abi == lowest_free(m_free), "R3 R8 buffer", 64'(spawn_abi), 64'(lowest_free(m_free)));
        q_ep[k]  = m_ep;
        q_abi[k] = lowest_free(m_free);
        m_free[q_abi[k]] = 1'b0;
        m_ep = ep_next(m_ep);
        @(posedge clk);
        #1 spawn_valid = 1'b0;
    endtask

    task automatic push(input int k);
        @(negedge clk);
        viol_flags[q_abi[k]] = q_viol[k];
        in_valid = 1'b1;
        in_fp = q_fp[k]; in_ip = q_ip[k]; in_rs = q_rs[k]; in_sc = q_sc[k];
        in_epoch = q_ep[k]; in_rip = q_rip[k]; in_abi = q_abi[k];
        #0;
        chk(in_ready == 1'b1, "R9 room", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic fill(input int k);
        q_fp[k] = AW'($urandom); q_ip[k] = AW'($urandom); q_rip[k] = AW'($urandom);
        q_rs[k] = RSW'($urandom); q_sc[k] = SCW'($urandom);
        q_viol[k] = ($urandom_range(0, 2) == 0);
    endtask

    task automatic serve(input int k);
        int n = 0;
        logic [63:0] snap;
        @(negedge clk);
        while (!(ps_valid || pl_valid) && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(!(ps_valid && pl_valid), "R11", 64'({ps_valid, pl_valid}), 64'd0);
        if (!q_viol[k]) begin
            chk(ps_valid == 1'b1, "R4 R5 commit offered", 64'(ps_valid), 64'd1);
            chk({ps_fp, ps_ip, ps_rs, ps_sc, ps_epoch, ps_rip, ps_abi} ==
                {q_fp[k], q_ip[k], q_rs[k], q_sc[k], q_ep[k], q_rip[k], q_abi[k]}, "R5 fields",
                64'({ps_fp, ps_ip, ps_rs, ps_sc, ps_epoch, ps_rip, ps_abi}),
                64'({q_fp[k], q_ip[k], q_rs[k], q_sc[k], q_ep[k], q_rip[k], q_abi[k]}));
            snap = 64'({ps_fp, ps_ip, ps_rs, ps_sc, ps_epoch, ps_rip, ps_abi});
            if ($urandom_range(0, 1) == 1) begin
                @(negedge clk);
                chk(ps_valid && (64'({ps_fp, ps_ip, ps_rs, ps_sc, ps_epoch, ps_rip, ps_abi}) == snap),
                    "R10 commit hold", 64'({ps_fp, ps_ip, ps_rs, ps_sc, ps_epoch, ps_rip, ps_abi}), snap);
            end
            ps_ready = 1'b1;
            @(posedge clk);
            #1 ps_ready = 1'b0;
        end else begin
            chk(pl_valid == 1'b1, "R6 retry offered", 64'(pl_valid), 64'd1);
            chk({pl_fp, pl_ip, pl_rs, pl_sc, pl_epoch, pl_rip, pl_abi} ==
                {q_fp[k], q_rip[k], q_rs[k], q_sc[k], EW'(0), AW'(0), BW'(0)}, "R6 rewrite",
                64'({pl_fp, pl_ip, pl_rs, pl_sc, pl_epoch, pl_rip, pl_abi}),
                64'({q_fp[k], q_rip[k], q_rs[k], q_sc[k], EW'(0), AW'(0), BW'(0)}));
            snap = 64'({pl_fp, pl_ip, pl_rs, pl_sc});
            if ($urandom_range(0, 1) == 1) begin
                @(negedge clk);
                chk(pl_valid && (64'({pl_fp, pl_ip, pl_rs, pl_sc}) == snap),
                    "R10 retry hold", 64'({pl_fp, pl_ip, pl_rs, pl_sc}), snap);
            end
            pl_ready = 1'b1;
            @(posedge clk);
            #1 pl_ready = 1'b0;
        end
        m_free[q_abi[k]] = 1'b1;
        viol_flags[q_abi[k]] = 1'b0;
        if (q_viol[k]) begin
            // R7: slot held until the retried thread reports completion
            repeat (5) begin
                @(negedge clk);
                chk(!ps_valid && !pl_valid, "R7 hold", 64'({ps_valid, pl_valid}), 64'd0);
            end
            retry_done = 1'b1;
            @(posedge clk);
            #1 retry_done = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(!ps_valid && !pl_valid, "R1 outputs idle", 64'({ps_valid, pl_valid}), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(spawn_ready && spawn_epoch == EW'(1) && spawn_abi == '0, "R1 spawn",
            64'({spawn_ready, spawn_epoch, spawn_abi}), 64'({1'b1, EW'(1), BW'(0)}));

        // R4: later epoch at the head stalls, no reordering
        for (int k = 0; k < 2; k++) begin fill(k); q_viol[k] = 1'b0; spawn(k); end
        push(1);
        repeat (8) begin
            @(negedge clk);
            chk(!ps_valid && !pl_valid, "R4 stall", 64'({ps_valid, pl_valid}), 64'd0);
        end
        push(0);
        repeat (8) begin
            @(negedge clk);
            chk(!ps_valid && !pl_valid, "R4 no reorder", 64'({ps_valid, pl_valid}), 64'd0);
        end
        do_reset();

        // R9 and R3: full queue with exhausted pool
        for (int k = 0; k < 4; k++) begin fill(k); spawn(k); push(k); end
        @(negedge clk);
        in_valid = 1'b1;
        #0;
        chk(in_ready == 1'b0, "R9 full", 64'(in_ready), 64'd0);
        chk(spawn_ready == 1'b0, "R3 pool empty", 64'(spawn_ready), 64'd0);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) serve(k);

        // Random rounds; epoch wraps many times (R2)
        for (int r = 0; r < 60; r++) begin
            int cnt = $urandom_range(1, 4);
            for (int k = 0; k < cnt; k++) begin fill(k); spawn(k); end
            for (int k = 0; k < cnt; k++) push(k);
            for (int k = 0; k < cnt; k++) serve(k);
        end

        // R8: all buffers returned
        @(negedge clk);
        chk(spawn_ready && spawn_abi == '0, "R8 pool refilled", 64'({spawn_ready, spawn_abi}), 64'({1'b1, BW'(0)}));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule